// File: doc/BRIEF.md
# Packed IMA ADPCM Pair Decoder

This block turns compressed IMA ADPCM audio into 8-bit PCM bytes for a processor that has only byte-wide I/O. The host writes one byte to the input port. That byte holds two 4-bit ADPCM codes. The block decodes the low code first and the high code second. Each decode moves the internal predictor and the step index forward, so the state carries over from one write to the next.

The host then reads the output port twice to collect the two decoded samples, in decode order. Each sample is the top byte of the 16-bit predictor with its sign bit inverted, so silence reads as 0x80. Further reads return the second sample. A new write starts the read order again at the first sample.

Decoding takes effect at the clock edge that accepts the write. A parameter can choose a serial build instead, which uses one nibble datapath twice and finishes two clock edges after the write. Both builds are ready well before a following I/O access could arrive.

Top module: `ima_pair_decoder`

## Requirements
- R1: After reset the predictor and the step index are both 0, and the output port reads 0x80 until the first write completes.
- R2: Of a written byte, bits 3:0 are decoded first and bits 7:4 second. The second decode starts from the state the first one left.
- R3: For a code with magnitude bits m2 m1 m0 (bits 2:0) and step s, the difference is (s>>3) + (m2 ? s : 0) + (m1 ? s>>1 : 0) + (m0 ? s>>2 : 0). Each term is truncated on its own.
- R4: Code bit 3 set subtracts the difference from the predictor. Clear adds it.
- R5: The predictor saturates at 32767 and at -32768. It never wraps.
- R6: The step index changes by -1 for magnitudes 0 to 3 and by +2, +4, +6, +8 for magnitudes 4 to 7. It is clamped to 0..88 and selects the standard 89-entry IMA step table, which starts at 7 and ends at 32767.
- R7: Each output byte is predictor bits 15:8 with bit 7 inverted (offset binary).
- R8: The first read after a write returns the low-code sample. The next read returns the high-code sample. Every read after that returns the high-code sample again.
- R9: A write resets the read order to the first sample, even when the previous pair was read only partly or not at all.
- R10: The predictor and the step index change only because of writes. The decoded pair can be read on the cycle after the write (default build) or three cycles after it (serial build).
- R11: If a write and a read strobe arrive in the same cycle, the write takes effect and the next read returns the new first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle strobe: accept a packed code byte |
| wr_byte | input | 8 | Two 4-bit ADPCM codes, low nibble decoded first |
| rd_stb | input | 1 | One-cycle strobe: the host consumed the current output byte |
| rd_byte | output | OUT_W (8) | Sample selected by the read order, offset binary |

## Verification
The bench first writes every one of the 256 code bytes in turn. This reaches every magnitude and sign pattern from many different predictor and index states, so an error in the difference terms, the sign handling or the index table shows up as a wrong output byte. Long runs of maximum-positive and maximum-negative codes then drive the predictor into both rails and the step index to 88. Runs of zero codes pull the index back to 0, which separates correct clamping from wraparound. Partly read pairs, writes that land on a read strobe, and a pseudo-random byte stream test the read order apart from the arithmetic.

// File: rtl/ima_pair_pkg.sv
`timescale 1ns/1ps
package ima_pair_pkg;

   localparam int PRED_W  = 16;
   localparam int CODE_W  = 4;
   localparam int MAG_W   = CODE_W - 1;
   localparam int IDX_W   = 7;
   localparam int IDX_TOP = 88;
   localparam int STEP_W  = 15;
   localparam int LO_N    = 45;
   localparam int HI_N    = IDX_TOP + 1 - LO_N;

   typedef logic [IDX_W-1:0]         idx_t;
   typedef logic signed [PRED_W-1:0] pred_t;
   typedef logic [STEP_W-1:0]        step_t;
   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

   localparam step_t STEP_LO [LO_N] = '{
      15'd7, 15'd8, 15'd9, 15'd10, 15'd11, 15'd12, 15'd13, 15'd14, 15'd16,
      15'd17, 15'd19, 15'd21, 15'd23, 15'd25, 15'd28, 15'd31, 15'd34, 15'd37,
      15'd41, 15'd45, 15'd50, 15'd55, 15'd60, 15'd66, 15'd73, 15'd80, 15'd88,
      15'd97, 15'd107, 15'd118, 15'd130, 15'd143, 15'd157, 15'd173, 15'd190,
      15'd209, 15'd230, 15'd253, 15'd279, 15'd307, 15'd337, 15'd371, 15'd408,
      15'd449, 15'd494};

   localparam step_t STEP_HI [HI_N] = '{
      15'd544, 15'd598, 15'd658, 15'd724, 15'd796, 15'd876, 15'd963, 15'd1060,
      15'd1166, 15'd1282, 15'd1411, 15'd1552, 15'd1707, 15'd1878, 15'd2066,
      15'd2272, 15'd2499, 15'd2749, 15'd3024, 15'd3327, 15'd3660, 15'd4026,
      15'd4428, 15'd4871, 15'd5358, 15'd5894, 15'd6484, 15'd7132, 15'd7845,
      15'd8630, 15'd9493, 15'd10442, 15'd11487, 15'd12635, 15'd13899,
      15'd15289, 15'd16818, 15'd18500, 15'd20350, 15'd22385, 15'd24623,
      15'd27086, 15'd29794, 15'd32767};

   function automatic step_t step_of(input idx_t i);
      idx_t k;
      k = i - idx_t'(LO_N);
      if (i > idx_t'(IDX_TOP))     return STEP_HI[HI_N-1];
      else if (i < idx_t'(LO_N))   return STEP_LO[i[5:0]];
      else                         return STEP_HI[k[5:0]];
   endfunction

endpackage

// File: rtl/ima_nibble_step.sv
`timescale 1ns/1ps
module ima_nibble_step
   import ima_pair_pkg::*;
(
   input  pred_t             pred_i,
   input  idx_t              idx_i,
   input  logic [CODE_W-1:0] code_i,
   output pred_t             pred_o,
   output idx_t              idx_o
);
   localparam int DIFF_W = STEP_W + 2;
   localparam int WIDE_W = PRED_W + 2;

   step_t               step;
   logic [DIFF_W-1:0]   part [MAG_W+1];
   logic signed [WIDE_W-1:0] ext, dif, wide;
   logic signed [7:0]   adj, nidx;

   assign step    = step_of(idx_i);
   assign part[0] = DIFF_W'(step >> MAG_W);

   // one adder per magnitude bit; bit j adds step >> (MAG_W-1-j)
   for (genvar j = 0; j < MAG_W; j++) begin : g_term
      assign part[j+1] = code_i[j] ? part[j] + DIFF_W'(step >> (MAG_W-1-j))
                                   : part[j];
   end

   assign ext = {{(WIDE_W-PRED_W){pred_i[PRED_W-1]}}, pred_i};
   assign dif = $signed({1'b0, part[MAG_W]});

   always_comb begin
      wide = code_i[CODE_W-1] ? ext - dif : ext + dif;
      if (wide > WIDE_W'(32767))
         pred_o = 16'sh7fff;
      else if (wide < -WIDE_W'(32768))
         pred_o = -16'sh8000;
      else
         pred_o = wide[PRED_W-1:0];
   end

   always_comb begin
      if (code_i[MAG_W-1])
         adj = $signed({4'b0, {1'b0, code_i[1:0]} + 3'd1, 1'b0});
      else
         adj = -8'sd1;
      nidx = $signed({1'b0, idx_i}) + adj;
      if (nidx < 8'sd0)
         idx_o = '0;
      else if (nidx > 8'(IDX_TOP))
         idx_o = idx_t'(IDX_TOP);
      else
         idx_o = nidx[IDX_W-1:0];
   end
endmodule

// File: rtl/ima_read_seq.sv
`timescale 1ns/1ps
module ima_read_seq #(
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OUT_W-1:0] first_i,
   input  logic [OUT_W-1:0] second_i,
   input  logic             adv,
   output logic [OUT_W-1:0] out_o
);
   localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W-1);

   logic [OUT_W-1:0] first_q, second_q;
   logic             ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q  <= MID;
         second_q <= MID;
         ptr_q    <= 1'b0;
      end else if (load) begin
         first_q  <= first_i;
         second_q <= second_i;
         ptr_q    <= 1'b0;
      end else if (adv) begin
         ptr_q    <= 1'b1;
      end
   end

   assign out_o = ptr_q ? second_q : first_q;

   // R9
   load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (out_o == $past(first_i)));

   // R8
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv && !ptr_q) |=> (out_o == $past(second_q)));

   // R8
   sticky_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && ptr_q) |=> $stable(out_o));
endmodule

// File: rtl/ima_pair_decoder.sv
`timescale 1ns/1ps
module ima_pair_decoder
   import ima_pair_pkg::*;
#(
   parameter int OUT_W  = 8,
   parameter bit SERIAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [7:0]       wr_byte,
   input  logic             rd_stb,
   output logic [OUT_W-1:0] rd_byte
);
   localparam logic [OUT_W-1:0] FLIP = OUT_W'(1) << (OUT_W-1);

   if (OUT_W < 1 || OUT_W > PRED_W) begin : g_bad_width
      $error("ima_pair_decoder: OUT_W must lie in 1..16");
   end
   if (2*CODE_W != 8) begin : g_bad_code
      $error("ima_pair_decoder: two codes must fill one byte");
   end

   pred_t            pred_q;
   idx_t             idx_q;
   logic             load;
   logic [OUT_W-1:0] ld_first, ld_second;

   if (!SERIAL) begin : g_cascade
      pred_t p_lo, p_hi;
      idx_t  i_lo, i_hi;

      ima_nibble_step u_lo (.pred_i(pred_q), .idx_i(idx_q),
                            .code_i(wr_byte[CODE_W-1:0]),
                            .pred_o(p_lo), .idx_o(i_lo));
      ima_nibble_step u_hi (.pred_i(p_lo), .idx_i(i_lo),
                            .code_i(wr_byte[2*CODE_W-1:CODE_W]),
                            .pred_o(p_hi), .idx_o(i_hi));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pred_q <= '0;
            idx_q  <= '0;
         end else if (wr_stb) begin
            pred_q <= p_hi;
            idx_q  <= i_hi;
         end
      end

      assign load      = wr_stb;
      assign ld_first  = p_lo[PRED_W-1 -: OUT_W] ^ FLIP;
      assign ld_second = p_hi[PRED_W-1 -: OUT_W] ^ FLIP;

      // R10
      state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_stb |=> ($stable(pred_q) && $stable(idx_q)));
   end else begin : g_serial
      phase_t           phase_q;
      logic [7:0]       hold_q;
      logic [OUT_W-1:0] first_q;
      pred_t            p_nx;
      idx_t             i_nx;
      logic [CODE_W-1:0] code;

      assign code = (phase_q == PH_HIGH) ? hold_q[2*CODE_W-1:CODE_W]
                                         : hold_q[CODE_W-1:0];

      ima_nibble_step u_one (.pred_i(pred_q), .idx_i(idx_q), .code_i(code),
                             .pred_o(p_nx), .idx_o(i_nx));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pred_q  <= '0;
            idx_q   <= '0;
            phase_q <= PH_IDLE;
            hold_q  <= '0;
            first_q <= FLIP;
         end else if (wr_stb) begin
            hold_q  <= wr_byte;
            phase_q <= PH_LOW;
         end else begin
            unique case (phase_q)
               PH_LOW: begin
                  pred_q  <= p_nx;
                  idx_q   <= i_nx;
                  first_q <= p_nx[PRED_W-1 -: OUT_W] ^ FLIP;
                  phase_q <= PH_HIGH;
               end
               PH_HIGH: begin
                  pred_q  <= p_nx;
                  idx_q   <= i_nx;
                  phase_q <= PH_IDLE;
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end

      assign load      = (phase_q == PH_HIGH) && !wr_stb;
      assign ld_first  = first_q;
      assign ld_second = p_nx[PRED_W-1 -: OUT_W] ^ FLIP;

      // R10
      state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_stb && phase_q == PH_IDLE) |=> ($stable(pred_q) && $stable(idx_q)));
   end

   ima_read_seq #(.OUT_W(OUT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(load),
      .first_i(ld_first), .second_i(ld_second),
      .adv(rd_stb), .out_o(rd_byte));

   // R6
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= idx_t'(IDX_TOP));

   // R6
   idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(idx_q) |-> ((idx_q > $past(idx_q)) ? (idx_q - $past(idx_q) <= 7'd16)
                                                   : ($past(idx_q) - idx_q <= 7'd2)));
endmodule

// File: tb/ima_pair_decoder_test.sv
`timescale 1ns/1ps
module ima_pair_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_byte;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int rp = 0;
   int ri = 0;
   int exp0 = 128;
   int exp1 = 128;

   int tab_a [45] = '{7, 8, 9, 10, 11, 12, 13, 14, 16, 17, 19, 21, 23, 25, 28,
      31, 34, 37, 41, 45, 50, 55, 60, 66, 73, 80, 88, 97, 107, 118, 130, 143,
      157, 173, 190, 209, 230, 253, 279, 307, 337, 371, 408, 449, 494};
   int tab_b [44] = '{544, 598, 658, 724, 796, 876, 963, 1060, 1166, 1282,
      1411, 1552, 1707, 1878, 2066, 2272, 2499, 2749, 3024, 3327, 3660, 4026,
      4428, 4871, 5358, 5894, 6484, 7132, 7845, 8630, 9493, 10442, 11487,
      12635, 13899, 15289, 16818, 18500, 20350, 22385, 24623, 27086, 29794,
      32767};

   always #2.5 clk = ~clk;

   ima_pair_decoder uut (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
      .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte));

   function automatic int to_out(int p);
      return ((p >>> 8) & 255) ^ 128;
   endfunction

   // R3 R4 R5 R6 reference arithmetic
   task automatic ref_nib(int c);
      int s, d;
      s = (ri < 45) ? tab_a[ri] : tab_b[ri-45];
      d = s >> 3;
      if (c & 4) d += s;
      if (c & 2) d += s >> 1;
      if (c & 1) d += s >> 2;
      rp = (c & 8) ? rp - d : rp + d;
      if (rp > 32767) rp = 32767;
      if (rp < -32768) rp = -32768;
      ri += ((c & 7) < 4) ? -1 : ((c & 7) - 3) * 2;
      if (ri < 0) ri = 0;
      if (ri > 88) ri = 88;
   endtask

   task automatic check(int got, int exp, string tag);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
      end
   endtask

   // R2 R10: model both nibbles, low first
   task automatic do_write(logic [7:0] b, bit with_rd);
      @(negedge clk);
      wr_stb = 1'b1; wr_byte = b; rd_stb = with_rd;
      @(negedge clk);
      wr_stb = 1'b0; rd_stb = 1'b0;
      ref_nib(int'(b[3:0])); exp0 = to_out(rp);
      ref_nib(int'(b[7:4])); exp1 = to_out(rp);
      repeat (2) @(negedge clk);
   endtask

   task automatic do_read(int exp, string tag);
      check(int'(rd_byte), exp, tag);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic full_pair(logic [7:0] b);
      do_write(b, 1'b0);
      do_read(exp0, "R2 R3 R4 R6 R7 R10 first");
      do_read(exp1, "R2 R3 R4 R6 R7 R8 second");
      do_read(exp1, "R8 repeat");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle output and zeroed state
      do_read(128, "R1 reset");
      do_read(128, "R1 reset again");
      full_pair(8'h00);
      check(exp0, 128, "R1 zero state");

      for (int b = 0; b < 256; b++) full_pair(8'(b));

      // R5 upper rail, index driven to its top
      for (int n = 0; n < 60; n++) full_pair(8'h77);
      check(int'(rd_byte), 255, "R5 upper rail");
      // R5 lower rail
      for (int n = 0; n < 60; n++) full_pair(8'hff);
      check(int'(rd_byte), 0, "R5 lower rail");
      // R6 index falls back to 0
      for (int n = 0; n < 50; n++) full_pair(8'h00);
      full_pair(8'h11);
      full_pair(8'h9c);

      // R9 partially read and unread pairs
      for (int n = 0; n < 20; n++) begin
         do_write(8'(n * 37 + 5), 1'b0);
         if (n % 2 == 0) do_read(exp0, "R9 partial");
         do_write(8'(n * 91 + 3), 1'b0);
         do_read(exp0, "R9 restart");
         do_read(exp1, "R9 second");
      end

      // R11 write and read strobe together
      for (int n = 0; n < 12; n++) begin
         do_write(8'(n * 53 + 17), 1'b0);
         do_read(exp0, "R11 setup");
         do_write(8'(n * 29 + 100), 1'b1);
         do_read(exp0, "R11 collide first");
         do_read(exp1, "R11 collide second");
      end

      // mixed stream
      begin
         logic [7:0] lf = 8'h5a;
         for (int n = 0; n < 300; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            full_pair(lf);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule